// File: doc/BRIEF.md
# Flash Block Write-Protect Unit

This unit sits between the CPU and the flash controller and decides, request by request, whether a program or erase command may reach the flash. It holds one 8-bit protect setting, which the CPU reads and writes over a simple one-cycle register bus. From that setting it derives a protection start address on a 512-byte page boundary. Every flash address from that start up to the top of the 16-bit space is then locked against modification.

The setting has two fixed bands. Low values place the start at or below the flash base, so the whole flash is locked. High values switch off the general protection. Whatever the setting, the last 48 bytes of the address space stay locked, because they hold the interrupt vectors.

Each request carries an address and an operation code. In the same cycle the unit returns either a grant or a reject. Only granted requests are forwarded to the flash controller. Read operations and addresses below the flash base are never blocked. The flash base and the register address are parameters.

Top module: `flash_wprot`

## Requirements
- R1: After reset the protect setting is 0x00, and a register read at the register address returns 0x00.
- R2: A bus write (bus_sel=1, bus_we=1) at REG_ADDR (default 0xFE09) stores bus_wdata, and a later read (bus_sel=1, bus_we=0) at that address returns it. A write to any other address leaves the setting unchanged. bus_rdata is 0x00 when no read of REG_ADDR is in progress.
- R3: For a setting v, the protection start is the 16-bit value {v[7:1], 9'b0}. A program or erase at a flash address at or above the start is rejected. A program or erase at a flash address below the start is granted, unless R7 applies.
- R4: Setting bit 0 has no effect on the boundary: v and v^1 give identical grant and reject results at every address.
- R5: Settings 0x00 through 0x71 lock the whole flash range, from FLASH_BASE (default 0x7000) to 0xFFFF.
- R6: Settings 0xF0 through 0xFF disable protection for all flash addresses below 0xFFD0.
- R7: A program or erase at any address from 0xFFD0 to 0xFFFF is rejected for every setting.
- R8: A request at an address below FLASH_BASE is granted for every setting and operation.
- R9: Operation codes are 2'b00 read, 2'b01 program, 2'b10 erase and 2'b11 reserved. Only program and erase are checked. Read and reserved requests are always granted.
- R10: A rejected request drives req_reject=1, req_grant=0 and fc_valid=0 in the same cycle. A granted request drives req_grant=1 and fc_valid=1, with fc_op and fc_addr equal to the request. With req_valid=0, all three flags are 0.
- R11: A write to the setting takes effect at the next clock edge. A request presented in the same cycle as the write is judged against the previous setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Register bus write enable |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data |
| req_valid | input | 1 | Flash request strobe |
| req_op | input | 2 | Flash operation code |
| req_addr | input | 16 | Flash request address |
| req_grant | output | 1 | Request allowed |
| req_reject | output | 1 | Request blocked by protection |
| fc_valid | output | 1 | Command strobe to the flash controller |
| fc_op | output | 2 | Operation forwarded to the flash controller |
| fc_addr | output | 16 | Address forwarded to the flash controller |

## Verification
The protect setting is the only state in the unit. A corrupted or mis-captured value shows up on bus_rdata at the first read after the write. It also moves the grant/reject boundary, which is visible in the same cycle as any program or erase request that falls between the true and the wrong start address. To catch boundary faults, every one of the 256 settings is swept against the addresses just below and at its start, and at both edges of the vector region. Any off-by-one in the start-address comparison or in the band decoding therefore flips a reject flag that is checked.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_RSVD  = 2'b11
   } fwp_op_e;

   function automatic logic op_modifies(input fwp_op_e op);
      return (op == OP_PROG) || (op == OP_ERASE);
   endfunction
endpackage

// File: rtl/fwp_setting_reg.sv
module fwp_setting_reg #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE09,
   parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] setting
);
   logic hit;
   logic wr_hit;

   assign hit    = sel && (addr == REG_ADDR);
   assign wr_hit = hit && we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      setting <= RST_VAL;
      else if (wr_hit) setting <= wdata;
   end

   assign rdata = (hit && !we) ? setting : '0;

   // R2 / R11: a write lands at the next edge, and nothing else changes the setting
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_hit && rst_n) |-> setting == $past(wdata));
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_hit && rst_n) |-> $stable(setting));
endmodule

// File: rtl/fwp_range.sv
module fwp_range #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h7000,
   parameter logic [DATA_W-1:0] NONE_MIN   = 8'hF0,
   parameter int VEC_BYTES = 48
) (
   input  logic [DATA_W-1:0] setting,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   localparam int PAGE_SH = ADDR_W - (DATA_W - 1);
   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] start;
   logic in_flash;
   logic none_band;
   logic vec_hit;

   assign start     = {setting[DATA_W-1:1], {PAGE_SH{1'b0}}};
   assign in_flash  = addr >= FLASH_BASE;
   assign none_band = setting >= NONE_MIN;

   generate
      if (VEC_BYTES > 0) begin : g_vec
         localparam logic [ADDR_W-1:0] VEC_LO = TOP_ADDR - ADDR_W'(VEC_BYTES - 1);
         assign vec_hit = addr >= VEC_LO;
      end else begin : g_novec
         assign vec_hit = 1'b0;
      end
   endgenerate

   assign locked = in_flash && (vec_hit || (!none_band && (addr >= start)));
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              locked,
   output logic              req_grant,
   output logic              req_reject,
   output logic              fc_valid,
   output logic [1:0]        fc_op,
   output logic [ADDR_W-1:0] fc_addr
);
   import fwp_pkg::*;

   fwp_op_e op;
   logic    modifies;

   assign op         = fwp_op_e'(req_op);
   assign modifies   = op_modifies(op);
   assign req_reject = req_valid && modifies && locked;
   assign req_grant  = req_valid && !(modifies && locked);
   assign fc_valid   = req_grant;
   assign fc_op      = req_op;
   assign fc_addr    = req_addr;

   // R10: a blocked command never reaches the flash controller
   assert_reject_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> !fc_valid && !req_grant);
   // R10: grant and reject are never raised together
   assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_grant && req_reject));
endmodule

// File: rtl/flash_wprot.sv
module flash_wprot #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h7000,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 16'hFE09,
   parameter logic [DATA_W-1:0] NONE_MIN   = 8'hF0,
   parameter int VEC_BYTES = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_grant,
   output logic              req_reject,
   output logic              fc_valid,
   output logic [1:0]        fc_op,
   output logic [ADDR_W-1:0] fc_addr
);
   localparam int PAGE_SH = ADDR_W - (DATA_W - 1);
   localparam logic [ADDR_W-1:0] VEC_LO = {ADDR_W{1'b1}} - ADDR_W'(VEC_BYTES - 1);

   generate
      if (PAGE_SH < 1) begin : g_bad_width
         $error("flash_wprot: ADDR_W must exceed DATA_W - 1");
      end
      if (VEC_BYTES < 1 || VEC_BYTES > (1 << PAGE_SH)) begin : g_bad_vec
         $error("flash_wprot: VEC_BYTES must lie within one protect page");
      end
   endgenerate

   logic [DATA_W-1:0] setting;
   logic              locked;

   fwp_setting_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .RST_VAL('0)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .setting(setting)
   );

   fwp_range #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLASH_BASE(FLASH_BASE),
      .NONE_MIN(NONE_MIN), .VEC_BYTES(VEC_BYTES)
   ) u_range (
      .setting(setting), .addr(req_addr), .locked(locked)
   );

   fwp_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .locked(locked), .req_grant(req_grant),
      .req_reject(req_reject), .fc_valid(fc_valid), .fc_op(fc_op), .fc_addr(fc_addr)
   );

   // R7: the vector region is locked for every setting
   assert_vector_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b01 || req_op == 2'b10) && req_addr >= VEC_LO)
      |-> req_reject);
   // R9: reads and reserved codes always pass
   assert_read_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 2'b00 || req_op == 2'b11)) |-> req_grant);
   // R8: addresses below the flash are never blocked
   assert_outside_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < FLASH_BASE) |-> !req_reject);
   // R10: no request, no flags
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !req_grant && !req_reject && !fc_valid);
endmodule

// File: tb/tb_flash_wprot.sv
module tb_flash_wprot;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [15:0] req_addr = '0;
   logic        req_grant, req_reject, fc_valid;
   logic [1:0]  fc_op;
   logic [15:0] fc_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   localparam logic [15:0] REG_A = 16'hFE09;

   always #4 clk = ~clk;

   flash_wprot dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_grant(req_grant), .req_reject(req_reject), .fc_valid(fc_valid),
      .fc_op(fc_op), .fc_addr(fc_addr)
   );

   function automatic bit ref_locked(input logic [7:0] v, input logic [15:0] a);
      if (a < 16'h7000) return 0;
      if (a >= 16'hFFD0) return 1;
      if (v >= 8'hF0) return 0;
      return a >= {v[7:1], 9'b0};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic try_req(input string tag, input logic [7:0] v, input logic [1:0] op,
                          input logic [15:0] a);
      bit modifies, exp_rej;
      req_valid = 1; req_op = op; req_addr = a;
      #1;
      modifies = (op == 2'b01) || (op == 2'b10);
      exp_rej  = modifies && ref_locked(v, a);
      chk({tag, " reject"}, req_reject, exp_rej);
      chk({tag, " grant"}, req_grant, !exp_rej);
      chk({tag, " fc_valid"}, fc_valid, !exp_rej);
      req_valid = 0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      #1 chk("R10 idle flags", {req_grant, req_reject, fc_valid}, 3'b000);
      bus_read(REG_A, d);
      chk("R1 reset value", d, 8'h00);
      @(negedge clk);
      try_req("R1 R5 reset locks base", 8'h00, 2'b01, 16'h7000);
   endtask

   task automatic t_regbus;
      logic [7:0] d;
      bus_write(REG_A, 8'hA5);
      bus_read(REG_A, d);
      chk("R2 readback", d, 8'hA5);
      bus_write(16'hFE08, 8'h3C);
      bus_read(REG_A, d);
      chk("R2 other address ignored", d, 8'hA5);
      @(negedge clk);
      bus_sel = 0; bus_addr = REG_A;
      #1 chk("R2 idle rdata", bus_rdata, 8'h00);
   endtask

   task automatic t_sweep;
      for (int v = 0; v < 256; v++) begin
         logic [15:0] st;
         logic [15:0] pts[5];
         st = {v[7:1], 9'b0};
         pts = '{st - 16'd1, st, 16'hFFCF, 16'hFFD0, 16'hFFFF};
         bus_write(REG_A, v[7:0]);
         @(negedge clk);
         for (int k = 0; k < 5; k++) begin
            try_req($sformatf("R3 R4 R7 v=%0h a=%0h prog", v, pts[k]), v[7:0], 2'b01, pts[k]);
            try_req($sformatf("R3 R7 v=%0h a=%0h erase", v, pts[k]), v[7:0], 2'b10, pts[k]);
         end
      end
   endtask

   task automatic t_bands;
      bus_write(REG_A, 8'h71);
      @(negedge clk);
      try_req("R5 0x71 base", 8'h71, 2'b10, 16'h7000);
      try_req("R5 0x71 mid", 8'h71, 2'b01, 16'hA123);
      bus_write(REG_A, 8'h73);
      @(negedge clk);
      try_req("R4 0x73 below", 8'h73, 2'b01, 16'h71FF);
      try_req("R4 0x73 start", 8'h73, 2'b01, 16'h7200);
      bus_write(REG_A, 8'hF0);
      @(negedge clk);
      try_req("R6 0xF0 high", 8'hF0, 2'b01, 16'hFFCF);
      try_req("R6 R7 0xF0 vector", 8'hF0, 2'b10, 16'hFFE0);
   endtask

   task automatic t_outside_reads;
      bus_write(REG_A, 8'h00);
      @(negedge clk);
      try_req("R8 below base prog", 8'h00, 2'b01, 16'h6FFF);
      try_req("R8 zero addr erase", 8'h00, 2'b10, 16'h0000);
      try_req("R9 read vector", 8'h00, 2'b00, 16'hFFFF);
      try_req("R9 reserved locked", 8'h00, 2'b11, 16'h8000);
      req_valid = 1; req_op = 2'b10; req_addr = 16'h5ABC;
      #1 chk("R10 fc_op", fc_op, 2'b10);
      chk("R10 fc_addr", fc_addr, 16'h5ABC);
      req_valid = 0;
   endtask

   task automatic t_same_cycle;
      bus_write(REG_A, 8'hF8);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = REG_A; bus_wdata = 8'h00;
      try_req("R11 old value same cycle", 8'hF8, 2'b01, 16'h9000);
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      try_req("R11 new value next cycle", 8'h00, 2'b01, 16'h9000);
   endtask

   task automatic finish_run;
      if (done) return;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_regbus();
      t_sweep();
      t_bands();
      t_outside_reads();
      t_same_cycle();
      finish_run();
   end
endmodule